// File: doc/BRIEF.md
# Stereo Volume and Mute Combiner

This block holds the playback level of eight DAC channels and of two master controls, one for the left side and one for the right side. Even-numbered DACs belong to the left side and odd-numbered DACs to the right. Each channel and each master has a 7-bit volume and a mute flag. When a control value actually changes, the block works out a new attenuation code for every DAC the change touches. It multiplies the channel volume by the master volume, divides the product by 127, and passes the quotient through a logarithmic table that the block builds itself. It then hands the code to a serial control-port writer as register writes, using a request/grant handshake.

Every new code is sent as a pair of writes to the DAC's attenuation register. The first write loads the code. The second write repeats the code with the two top data bits set, and this makes the code take effect. A set of pending flags, one per DAC, serializes the work. If a DAC is changed again while its flag is already set, the later change merges into the one pending recompute. The values are read at the moment the DAC is picked, so the newest state is what gets written.

Top module: `stereo_atten_ctl`

## Requirements
- R1: At reset every channel and both masters are muted, every volume is 0, and every DAC is then written with code 0, in ascending DAC order. `wr_req` is low while reset is held.
- R2: An update is taken when `upd_en` is high at a clock edge. `upd_sel` values 0 to 7 pick a channel, 8 picks the left master, 9 picks the right master, and 10 to 15 are ignored. With `upd_mute`=1, `upd_val[0]` is the new mute flag (1 = muted). With `upd_mute`=0, `upd_val` is the new volume. A volume above 127 is ignored and leaves the state unchanged.
- R3: A DAC whose channel mute is set, or whose side's master mute is set, gets code 0.
- R4: Otherwise the code is 127 − T[(vol·master / 127) & 255]. The division truncates. T[0] = 127, and T[x] = 20·log10(255/x) rounded to the nearest integer.
- R5: Each code goes out as two writes to address = DAC index (0x00 to 0x07). The first carries the code with bits 8:7 = 00. The second follows at once, to the same address, with the code ORed with 0x180.
- R6: A change of the left master recomputes DACs 0, 2, 4 and 6. A change of the right master recomputes DACs 1, 3, 5 and 7. Pending DACs are issued in ascending index order.
- R7: An update that leaves a volume or a mute flag at its current value causes no write.
- R8: A DAC is pending at most once. Several changes made before it is picked produce a single write pair that carries the latest state.
- R9: `wr_req` stays high with stable address and data until `wr_gnt` is high at a clock edge, which completes the transfer. After the second write of a pair completes, `wr_req` is low for at least one cycle.
- R10: A change that arrives while its DAC is being picked or computed leads to a further write pair carrying the newest state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Update strobe |
| upd_sel | input | 4 | Target: channel 0-7, left master 8, right master 9 |
| upd_mute | input | 1 | 1 = mute update, 0 = volume update |
| upd_val | input | 8 | Volume (0-127), or the mute flag in bit 0 |
| wr_gnt | input | 1 | Writer accepts the current write |
| wr_req | output | 1 | Write request pending |
| wr_addr | output | 7 | Register address (DAC index) |
| wr_data | output | 9 | Register value |

## Verification
Two events can fall in the same clock edge: an update that marks a DAC pending, and the issue engine clearing that same DAC's flag as it picks it. The bench provokes this by sending a new volume to one channel on every cycle, with the grant held high. Because updates arrive back to back, some of them land exactly on the pick and some land during the compute steps. The run is judged at the ports: every write must target that DAC and come as a well-formed pair, and the last pair must carry the code for the final volume. A second scenario stalls the grant and piles several changes onto a DAC that is already waiting, then checks that the merged result is written exactly once.

// File: rtl/stereo_atten_ctl.sv
module stereo_atten_ctl #(
  parameter int NDAC = 8,
  parameter int VW   = 7,
  parameter int AW   = 7,
  parameter int SELW = $clog2(NDAC + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic [SELW-1:0] upd_sel,
  input  logic            upd_mute,
  input  logic [VW:0]     upd_val,
  input  logic            wr_gnt,
  output logic            wr_req,
  output logic [AW-1:0]   wr_addr,
  output logic [VW+1:0]   wr_data
);
  localparam int IW    = $clog2(NDAC);
  localparam int VMAX  = (1 << VW) - 1;
  localparam int LREF  = (1 << (VW + 1)) - 1;
  localparam int SH    = 3 * VW + 1;
  localparam int RECIP = ((1 << SH) + VMAX - 1) / VMAX;
  localparam int RW    = $clog2(RECIP + 1);
  localparam int PW    = 2 * VW + RW;
  localparam int QW    = PW - SH;
  localparam int NLUT  = 1 << QW;

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_DIV, S_PRE, S_UPD} st_t;

  function automatic logic [VW-1:0] lut_f(input int x);
    real db;
    int  n;
    if (x == 0) return VW'(VMAX);
    db = 20.0 * $log10(real'(LREF) / real'(x));
    n  = $rtoi(db + 0.5);
    if (n > VMAX) n = VMAX;
    if (n < 0) n = 0;
    return VW'(n);
  endfunction

  st_t            st;
  logic [VW-1:0]  vol  [NDAC];
  logic [NDAC-1:0] mute;
  logic [VW-1:0]  mvol [2];
  logic [1:0]     mmute;
  logic [NDAC-1:0] pend, set_m, pick_m, even_m;
  logic [IW-1:0]  cur, nxt;
  logic [2*VW-1:0] prod_q;
  logic           mute_q;
  logic [VW-1:0]  code_q;
  logic [PW-1:0]  scaled;
  logic [QW-1:0]  quot;
  logic [VW-1:0]  rom [NLUT];

  for (genvar g = 0; g < NLUT; g++) begin : g_rom
    assign rom[g] = lut_f(g);
  end

  for (genvar g = 0; g < NDAC; g++) begin : g_side
    assign even_m[g] = (g % 2 == 0);
  end

  wire          side   = upd_sel[0];
  wire [IW-1:0] ch     = upd_sel[IW-1:0];
  wire          sel_ch = upd_sel < SELW'(NDAC);
  wire          sel_ms = !sel_ch && (upd_sel < SELW'(NDAC + 2));
  wire          vol_ok = !upd_val[VW];

  wire chg_ch = upd_en && sel_ch &&
                (upd_mute ? (mute[ch] != upd_val[0])
                          : (vol_ok && vol[ch] != upd_val[VW-1:0]));
  wire chg_ms = upd_en && sel_ms &&
                (upd_mute ? (mmute[side] != upd_val[0])
                          : (vol_ok && mvol[side] != upd_val[VW-1:0]));

  always_comb begin
    if (chg_ch)      set_m = NDAC'(1) << ch;
    else if (chg_ms) set_m = side ? ~even_m : even_m;
    else             set_m = '0;
  end

  always_comb begin
    nxt = '0;
    for (int i = NDAC - 1; i >= 0; i--)
      if (pend[i]) nxt = IW'(i);
  end

  assign pick_m = (st == S_IDLE && |pend) ? (NDAC'(1) << nxt) : '0;

  assign scaled = PW'(prod_q) * PW'(RECIP);
  assign quot   = scaled[PW-1:SH];

  assign wr_req  = (st == S_PRE) || (st == S_UPD);
  assign wr_addr = AW'(cur);
  assign wr_data = {{2{st == S_UPD}}, code_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= '1;
      mute   <= '1;
      mmute  <= '1;
      for (int i = 0; i < NDAC; i++) vol[i] <= '0;
      mvol[0] <= '0;
      mvol[1] <= '0;
      cur    <= '0;
      prod_q <= '0;
      mute_q <= 1'b1;
      code_q <= '0;
    end else begin
      pend <= (pend & ~pick_m) | set_m;
      if (chg_ch) begin
        if (upd_mute) mute[ch] <= upd_val[0];
        else          vol[ch]  <= upd_val[VW-1:0];
      end
      if (chg_ms) begin
        if (upd_mute) mmute[side] <= upd_val[0];
        else          mvol[side]  <= upd_val[VW-1:0];
      end
      case (st)
        S_IDLE: if (|pend) begin
          cur <= nxt;
          st  <= S_MUL;
        end
        S_MUL: begin
          prod_q <= (2*VW)'(vol[cur]) * (2*VW)'(mvol[cur[0]]);
          mute_q <= mute[cur] | mmute[cur[0]];
          st     <= S_DIV;
        end
        S_DIV: begin
          code_q <= mute_q ? '0 : VW'(VMAX) - rom[quot];
          st     <= S_PRE;
        end
        S_PRE: if (wr_gnt) st <= S_UPD;
        S_UPD: if (wr_gnt) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_gnt |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  // R5
  upd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_gnt && !wr_data[VW+1] |=>
      wr_req && wr_addr == $past(wr_addr) &&
      wr_data == ($past(wr_data) | {2'b11, {VW{1'b0}}}));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr < AW'(NDAC));

  // R9
  pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_gnt && wr_data[VW+1] |=> !wr_req);

  // R3
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && mute_q |-> wr_data[VW-1:0] == '0);

endmodule

// File: tb/tb_stereo_atten_ctl.sv
`timescale 1ns/1ps
module tb_stereo_atten_ctl;
  logic clk = 0, rst_n = 0, upd_en = 0, upd_mute = 0, wr_gnt = 1;
  logic [3:0] upd_sel = '0;
  logic [7:0] upd_val = '0;
  logic       wr_req;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;

  stereo_atten_ctl dut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_sel(upd_sel),
    .upd_mute(upd_mute), .upd_val(upd_val), .wr_gnt(wr_gnt),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data));

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0, n = 0;
  bit done = 0;
  int la [256];
  int ld [256];
  int cvol [8];
  int cmute [8];
  int mv [2];
  int mm [2];

  always @(negedge clk)
    if (rst_n && wr_req && wr_gnt) begin
      la[n % 256] = wr_addr;
      ld[n % 256] = wr_data;
      n++;
    end

  function automatic int lut(int x);
    if (x == 0) return 127;
    return $rtoi(20.0 * $log10(255.0 / x) + 0.5);
  endfunction

  function automatic int ecode(int c);
    int s = c % 2;
    if (cmute[c] != 0 || mm[s] != 0) return 0;
    return 127 - lut(((cvol[c] * mv[s]) / 127) & 255);
  endfunction

  function automatic int model_apply(int sel, bit m, int val);
    int mask = 0;
    if (sel < 8) begin
      if (m) begin
        if (cmute[sel] != (val & 1)) begin cmute[sel] = val & 1; mask = 1 << sel; end
      end else if (val <= 127 && cvol[sel] != val) begin
        cvol[sel] = val; mask = 1 << sel;
      end
    end else if (sel < 10) begin
      int s = sel - 8;
      bit c = 0;
      if (m) begin
        if (mm[s] != (val & 1)) begin mm[s] = val & 1; c = 1; end
      end else if (val <= 127 && mv[s] != val) begin
        mv[s] = val; c = 1;
      end
      if (c) mask = s ? 'hAA : 'h55;
    end
    return mask;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive(int sel, bit m, int val);
    tick();
    upd_en = 1; upd_sel = 4'(sel); upd_mute = m; upd_val = 8'(val);
    tick();
    upd_en = 0;
  endtask

  task automatic settle();
    int idle = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (wr_req) idle = 0; else idle++;
      if (idle >= 8) break;
    end
  endtask

  task automatic upd(string tag, int sel, bit m, int val);
    int mask, base, k;
    mask = model_apply(sel, m, val);
    base = n;
    drive(sel, m, val);
    settle();
    k = 0;
    for (int i = 0; i < 8; i++)
      if (mask[i]) begin
        int c = ecode(i);
        chk(tag, la[(base + k) % 256], i);
        chk(tag, ld[(base + k) % 256], c);
        chk(tag, la[(base + k + 1) % 256], i);
        chk(tag, ld[(base + k + 1) % 256], c | 384);
        k += 2;
      end
    chk(tag, n - base, k);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R9 actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int c10, c30, c3, base;
    for (int i = 0; i < 8; i++) begin cvol[i] = 0; cmute[i] = 1; end
    mv[0] = 0; mv[1] = 0; mm[0] = 1; mm[1] = 1;

    // R1: reset state and initial write-out
    repeat (3) @(negedge clk);
    chk("R1", wr_req, 0);
    tick(); rst_n = 1;
    settle();
    chk("R1", n, 16);
    for (int i = 0; i < 8; i++) begin
      chk("R1/R5", la[2*i], i);
      chk("R1/R5", ld[2*i], 0);
      chk("R1/R5", la[2*i+1], i);
      chk("R1/R5", ld[2*i+1], 384);
    end

    // R6: master fan-out, R7: no-change, R2: ignored updates
    upd("R6", 8, 1, 0);
    upd("R7", 8, 1, 0);
    upd("R6", 8, 0, 127);
    upd("R7", 8, 0, 127);
    upd("R6", 9, 1, 0);
    upd("R6", 9, 0, 100);
    upd("R2", 8, 0, 128);
    upd("R2", 9, 0, 255);
    upd("R2", 12, 0, 5);
    upd("R2", 15, 1, 1);
    upd("R3", 0, 1, 0);
    upd("R3", 1, 1, 0);
    upd("R3", 3, 1, 0);
    upd("R4", 0, 0, 127);
    upd("R2", 0, 0, 200);
    upd("R7", 0, 0, 127);

    // R8 and R9: stall the writer and merge changes
    wr_gnt = 0;
    void'(model_apply(1, 0, 10)); drive(1, 0, 10); c10 = ecode(1);
    repeat (6) tick();
    @(negedge clk);
    chk("R9", wr_req, 1);
    chk("R9", wr_addr, 1);
    chk("R9", wr_data, c10);
    void'(model_apply(1, 0, 20)); drive(1, 0, 20);
    void'(model_apply(1, 0, 30)); drive(1, 0, 30); c30 = ecode(1);
    void'(model_apply(3, 0, 5)); drive(3, 0, 5);
    void'(model_apply(3, 0, 6)); drive(3, 0, 6); c3 = ecode(3);
    @(negedge clk);
    chk("R9", wr_req, 1);
    chk("R9", wr_data, c10);
    tick();
    base = n;
    wr_gnt = 1;
    settle();
    chk("R8", n - base, 6);
    chk("R8", la[(base) % 256], 1);     chk("R8", ld[(base) % 256], c10);
    chk("R8", la[(base+1) % 256], 1);   chk("R8", ld[(base+1) % 256], c10 | 384);
    chk("R8", la[(base+2) % 256], 1);   chk("R8", ld[(base+2) % 256], c30);
    chk("R8", la[(base+3) % 256], 1);   chk("R8", ld[(base+3) % 256], c30 | 384);
    chk("R8", la[(base+4) % 256], 3);   chk("R8", ld[(base+4) % 256], c3);
    chk("R8", la[(base+5) % 256], 3);   chk("R8", ld[(base+5) % 256], c3 | 384);

    // R4: sweep of channel volume against left master levels
    for (int j = 0; j <= 26; j++) begin
      int m = (j == 26) ? 127 : j * 5;
      upd("R6", 8, 0, m);
      for (int v = 0; v < 128; v++) upd("R4", 0, 0, v);
    end

    // R4: right side sweep on the last DAC
    upd("R3", 7, 1, 0);
    for (int j = 0; j < 3; j++) begin
      int m = (j == 0) ? 1 : (j == 1) ? 64 : 127;
      upd("R6", 9, 0, m);
      for (int v = 0; v < 128; v++) upd("R4", 7, 0, v);
    end

    // R3: mutes force code 0
    upd("R3", 0, 1, 1);
    upd("R7", 0, 1, 1);
    upd("R3", 0, 1, 0);
    upd("R3", 8, 1, 1);
    upd("R3", 8, 1, 0);
    upd("R3", 9, 1, 1);
    upd("R3", 9, 1, 0);

    // R10: back-to-back updates collide with pick and compute
    upd("R10", 0, 0, 0);
    base = n;
    for (int v = 1; v <= 24; v++) begin
      void'(model_apply(0, 0, v));
      tick();
      upd_en = 1; upd_sel = 4'd0; upd_mute = 0; upd_val = 8'(v);
    end
    tick();
    upd_en = 0;
    settle();
    chk("R10", ((n - base) % 2 == 0 && n - base >= 2) ? 1 : 0, 1);
    for (int k = base; k < n; k += 2) begin
      chk("R10", la[k % 256], 0);
      chk("R10", la[(k + 1) % 256], 0);
      chk("R10", ld[(k + 1) % 256], ld[k % 256] | 384);
    end
    chk("R10", ld[(n - 2) % 256], ecode(0));
    chk("R10", ld[(n - 1) % 256], ecode(0) | 384);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule